// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Loader

The block takes configuration words from a three-wire serial port (serial clock, serial data, load strobe) and writes each word into one of six on-chip control registers. The three serial pins and the chip-enable pin are asynchronous to the system clock. Each passes through a synchronizer, and edges are found from the synchronized samples. The system clock therefore has to run fast enough to see serial clock phases as short as 25 ns.

Each serial clock rising edge shifts one data bit into a 32-bit word, most significant bit first. A rising edge on the load strobe copies the word into the register that its three lowest bits select. The whole word is stored, control bits included. Every register is visible on a flat parallel output bus. Each accepted load also raises a one-cycle write strobe together with the destination address. A power-down output combines the chip-enable pin with a power-down bit held in register 2.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each synchronized rising edge of `sclk`, the value of `sdata` shifts into a 32-bit word. The first bit clocked in ends up as bit 31 and the last one as bit 0.
- R2: A rising edge on `sle` copies the whole 32-bit word, control bits included, into register number `word[2:0]`. Register k occupies `regs_flat[32*k+31:32*k]`.
- R3: For each accepted load, `wr_stb` is high for exactly one system clock cycle and `wr_addr` carries the register number. Strobe and register update appear on the third rising system clock edge after `sle` goes high.
- R4: A load whose `word[2:0]` is 6 or 7 produces no strobe and leaves all six registers unchanged.
- R5: `sclk` edges that arrive while `sle` is high are still shifted in. An `sle` level that stays high causes no further transfer; only the next rising edge does.
- R6: Reset (`rst_n` low) clears all registers and the shift word. A load taken with no bits shifted since reset writes zero to register 0.
- R7: `pwr_down` is high when the synchronized `ce` is low, or when bit 5 of register 2 is set. A change on `ce` reaches `pwr_down` after two system clock edges.
- R8: A load changes only the register it addresses. The other five keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first |
| sle | input | 1 | Load strobe; a rising edge transfers the word |
| ce | input | 1 | Chip enable; low requests power-down |
| regs_flat | output | 192 | Six 32-bit registers, register k at bits 32k+31:32k |
| wr_stb | output | 1 | One-cycle pulse per accepted load |
| wr_addr | output | 3 | Destination register of the current strobe |
| pwr_down | output | 1 | Power-down request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, three select bits, six registers, two synchronizer stages, and the power-down flag at register 2, bit 5. With these values every valid code is reachable, as are both ignored codes and the power-down bit. The two-stage synchronizer fixes the strobe latency at three system cycles, and the bench checks that latency exactly. Directed cases cover bits shifted while the load strobe is held high, a reset in the middle of a run that must also clear the shift word, and the power-down output under both of its causes.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int WORD_W      = 32,
  parameter int SEL_W       = 3,
  parameter int NUM_REGS    = 6,
  parameter int SYNC_STAGES = 2,
  parameter int PD_REG      = 2,
  parameter int PD_BIT      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       sdata,
  input  logic                       sle,
  input  logic                       ce,
  output logic [NUM_REGS*WORD_W-1:0] regs_flat,
  output logic                       wr_stb,
  output logic [SEL_W-1:0]           wr_addr,
  output logic                       pwr_down
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [SEL_W:0] NREG = NUM_REGS[SEL_W:0];

  logic [SYNC_STAGES-1:0] sclk_q, sdat_q, sle_q, ce_q;
  logic                   sclk_d, sle_d;
  logic [WORD_W-1:0]      shreg;
  logic [WORD_W-1:0]      regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      sle_q  <= '0;
      ce_q   <= '0;
      sclk_d <= 1'b0;
      sle_d  <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk};
      sdat_q <= {sdat_q[TOP-1:0], sdata};
      sle_q  <= {sle_q[TOP-1:0], sle};
      ce_q   <= {ce_q[TOP-1:0], ce};
      sclk_d <= sclk_q[TOP];
      sle_d  <= sle_q[TOP];
    end

  wire              sclk_rise = sclk_q[TOP] & ~sclk_d;
  wire              le_rise   = sle_q[TOP] & ~sle_d;
  wire [SEL_W-1:0]  sel       = shreg[SEL_W-1:0];
  wire              sel_ok    = {1'b0, sel} < NREG;
  wire              do_load   = le_rise & sel_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_q[TOP]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_stb  <= do_load;
      if (do_load) wr_addr <= sel;
    end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                   regs[k] <= '0;
      else if (do_load && sel == k[SEL_W-1:0])      regs[k] <= shreg;
    assign regs_flat[k*WORD_W +: WORD_W] = regs[k];
  end

  assign pwr_down = ~ce_q[TOP] | regs[PD_REG][PD_BIT];
endmodule

module serial_cfg_loader_chk #(
  parameter int WORD_W   = 32,
  parameter int SEL_W    = 3,
  parameter int NUM_REGS = 6,
  parameter int PD_REG   = 2,
  parameter int PD_BIT   = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ce,
  input logic [NUM_REGS*WORD_W-1:0] regs_flat,
  input logic                       wr_stb,
  input logic [SEL_W-1:0]           wr_addr,
  input logic                       pwr_down
);
  assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_addr_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_addr) < NUM_REGS));

  assert_ctrl_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (regs_flat[int'(wr_addr)*WORD_W +: SEL_W] == wr_addr));

  assert_no_silent_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(regs_flat));

  assert_pd_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[PD_REG*WORD_W + PD_BIT] |-> pwr_down);

  assert_ce_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && $past(!ce) && $past(!ce, 2) && $past(rst_n, 2)) |-> pwr_down);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .WORD_W(WORD_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS),
  .PD_REG(PD_REG), .PD_BIT(PD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .regs_flat(regs_flat),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .pwr_down(pwr_down)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'hA5A5_0000, 32'h1357_9BD1, 32'hDEAD_BEE2, 32'h0F0F_F0F3,
    32'h8000_0004, 32'hFFFF_FFF5, 32'h1234_5676, 32'hCAFE_0027,
    32'h0000_0022, 32'h7FFF_FFF9
  };

  logic clk = 0, rst_n = 0, sclk = 0, sdata = 0, sle = 0, ce = 0;
  logic [191:0] regs_flat;
  logic wr_stb, pwr_down;
  logic [2:0] wr_addr;
  logic [31:0] exp_r [6];
  int checks = 0, fails = 0;
  bit done = 0;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sle(sle), .ce(ce),
    .regs_flat(regs_flat), .wr_stb(wr_stb), .wr_addr(wr_addr), .pwr_down(pwr_down));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic raise_le(output int nstb, output int first, output logic [2:0] a);
    nstb = 0; first = -1; a = '0;
    @(negedge clk);
    sle = 1;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (wr_stb) begin
        nstb++;
        if (first < 0) first = c;
        a = wr_addr;
      end
    end
  endtask

  task automatic drop_le();
    sle = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < 6; k++)
      chk(regs_flat[k*32 +: 32] === exp_r[k], tag, regs_flat[k*32 +: 32], exp_r[k]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, f;
    logic [2:0] a;
    logic [31:0] w;
    for (int k = 0; k < 6; k++) exp_r[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R6 reset state, R7 ce low
    check_regs("R6 reset regs");
    chk(wr_stb === 1'b0, "R6 reset strobe", {31'b0, wr_stb}, 0);
    chk(pwr_down === 1'b1, "R7 ce low", {31'b0, pwr_down}, 1);
    @(negedge clk); ce = 1;
    @(negedge clk);
    chk(pwr_down === 1'b1, "R7 ce latency 1", {31'b0, pwr_down}, 1);
    @(negedge clk);
    chk(pwr_down === 1'b0, "R7 ce released", {31'b0, pwr_down}, 0);

    // R1 R2 R3 R4 R8: vector table
    for (int v = 0; v < NV; v++) begin
      w = VEC[v];
      send_word(w);
      raise_le(n, f, a);
      drop_le();
      if (w[2:0] < 3'd6) begin
        exp_r[w[2:0]] = w;
        chk(n == 1, "R3 one strobe", n, 1);
        chk(f == 3, "R3 strobe latency", f, 3);
        chk(a == w[2:0], "R2 address", {29'b0, a}, {29'b0, w[2:0]});
      end else begin
        chk(n == 0, "R4 ignored code", n, 0);
      end
      check_regs("R1 R8 register contents");
      chk(pwr_down === exp_r[2][5], "R7 power-down bit", {31'b0, pwr_down}, {31'b0, exp_r[2][5]});
    end

    // R5: bits shifted while sle is high, level does not retrigger
    w = 32'h1234_5678;
    send_word(w);
    raise_le(n, f, a);
    exp_r[0] = w;
    chk(n == 1, "R5 first load", n, 1);
    shift_bit(1); shift_bit(0); shift_bit(1);
    repeat (6) @(negedge clk);
    chk(wr_stb === 1'b0, "R5 no retrigger while high", {31'b0, wr_stb}, 0);
    check_regs("R5 held high");
    drop_le();
    raise_le(n, f, a);
    drop_le();
    exp_r[5] = {w[28:0], 3'b101};
    chk(n == 1 && a == 3'd5, "R5 shifted while high", {29'b0, a}, 5);
    check_regs("R5 contents");

    // R7: ce low with register bit clear
    ce = 0;
    repeat (3) @(negedge clk);
    chk(pwr_down === 1'b1, "R7 ce low again", {31'b0, pwr_down}, 1);
    ce = 1;
    repeat (3) @(negedge clk);

    // R6: mid-run reset clears registers and shift word
    send_word(32'hFFFF_0001);
    shift_bit(1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) exp_r[k] = '0;
    check_regs("R6 mid-run reset");
    raise_le(n, f, a);
    drop_le();
    chk(n == 1 && a == 3'd0, "R6 cleared shift word", {29'b0, a}, 0);
    check_regs("R6 zero written");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule